// File: doc/BRIEF.md
# Interrupt Status and Mask Controller

This block collects ten single-cycle event pulses into a sticky pending register and drives a level interrupt line from it. Software clears pending bits by writing ones to them, and can also force pending bits through a dedicated set strobe register. The mask register cannot be written directly. It changes only through an unmask strobe register, which clears mask bits, and a mask strobe register, which sets them. Every source starts out masked.

The block also holds a small global control register. Writing that register with its scan-request bit set immediately records two outcome bits in a read-only unit status word: a scan-pass bit and a scan-done bit. The unit status word comes out of reset with its completion bit already set.

Access uses a plain synchronous register port with byte addresses. A write takes effect at the clock edge on which `wr_en` is high. Reads are combinational from `addr`.

Top module: `irq_event_ctrl`

## Requirements
- R1: The pending register is at offset 0x00 and its bits [9:0] are valid. Writing 1 to a bit clears it and writing 0 leaves it unchanged. Bits [31:10] always read zero.
- R2: The mask register is at offset 0x04. It resets to 0x3FF (all sources masked), and a direct write to offset 0x04 has no effect on it.
- R3: A write to the unmask strobe at offset 0x08 clears every mask bit whose write-data bit is 1 and leaves the other mask bits unchanged.
- R4: A write to the mask strobe at offset 0x0C sets every mask bit whose write-data bit is 1 and leaves the other mask bits unchanged.
- R5: A write to the force strobe at offset 0x10 sets every pending bit whose write-data bit [9:0] is 1.
- R6: `irq` is high exactly when some pending bit is 1 while its mask bit is 0. It reflects the register state from the cycle after each write.
- R7: The global control register at offset 0x18 stores write-data bits [14:0] and reads them back, with bits [31:15] reading zero. A write with bit 13 set also sets bit 13 (scan pass) and bit 3 (scan done) of the unit status word.
- R8: The unit status word at offset 0x100 reads 0x4 after reset, with bit 2 as the completion flag. Writes to offset 0x100 are ignored.
- R9: Reads of offsets 0x08, 0x0C and 0x10 return zero, as do reads of unmapped offsets.
- R10: A 1 on `evt_in[k]` at a clock edge sets pending bit k. If a write-1-to-clear of the same bit happens on the same edge, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the current address |
| addr | input | 9 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| evt_in | input | 10 | Hardware event pulses, one per source |
| irq | output | 1 | Level interrupt request |

## Verification
A wrong pending or mask bit appears at `irq` in the cycle after the write or event that should have changed it. Readback through offsets 0x00 and 0x04 shows the same fault in that cycle. A strobe that touches the wrong bit shows up when single sources are swept one at a time. A wrong rule for the same-edge event and clear only shows up when both happen on one edge, so that case is driven on purpose. The unit status and control words are read back straight after each control write, so a lost or stray scan bit is seen one cycle after the write.

// File: rtl/irq_event_ctrl.sv
module irq_event_ctrl #(
  parameter int NSRC   = 10,
  parameter int ADDR_W = 9,
  parameter int DW     = 32,
  parameter int GCTL_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic [NSRC-1:0]   evt_in,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_PEND   = ADDR_W'(9'h000);
  localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(9'h004);
  localparam logic [ADDR_W-1:0] A_UNMASK = ADDR_W'(9'h008);
  localparam logic [ADDR_W-1:0] A_SETMSK = ADDR_W'(9'h00C);
  localparam logic [ADDR_W-1:0] A_FORCE  = ADDR_W'(9'h010);
  localparam logic [ADDR_W-1:0] A_GCTL   = ADDR_W'(9'h018);
  localparam logic [ADDR_W-1:0] A_USTAT  = ADDR_W'(9'h100);
  localparam int SCAN_REQ  = 13;
  localparam int SCAN_PASS = 13;
  localparam int SCAN_DONE = 3;
  localparam int CMPL      = 2;

  logic [NSRC-1:0]   pend, mask;
  logic [GCTL_W-1:0] gctl;
  logic [DW-1:0]     ustat;
  logic [NSRC-1:0]   wbits;

  assign wbits = wdata[NSRC-1:0];

  wire wr_pend  = wr_en && addr == A_PEND;
  wire wr_unm   = wr_en && addr == A_UNMASK;
  wire wr_msk   = wr_en && addr == A_SETMSK;
  wire wr_force = wr_en && addr == A_FORCE;
  wire wr_gctl  = wr_en && addr == A_GCTL;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
    end else begin
      pend <= (pend & ~(wr_pend ? wbits : '0))
            | (wr_force ? wbits : '0)
            | evt_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask <= '1;
    end else if (wr_unm) begin
      mask <= mask & ~wbits;
    end else if (wr_msk) begin
      mask <= mask | wbits;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gctl  <= '0;
      ustat <= DW'(1) << CMPL;
    end else if (wr_gctl) begin
      gctl <= wdata[GCTL_W-1:0];
      if (wdata[SCAN_REQ]) begin
        ustat[SCAN_PASS] <= 1'b1;
        ustat[SCAN_DONE] <= 1'b1;
      end
    end
  end

  assign irq = |(pend & ~mask);

  always_comb begin
    rdata = '0;
    case (addr)
      A_PEND:  rdata[NSRC-1:0]   = pend;
      A_MASK:  rdata[NSRC-1:0]   = mask;
      A_GCTL:  rdata[GCTL_W-1:0] = gctl;
      A_USTAT: rdata             = ustat;
      default: rdata = '0;
    endcase
  end
endmodule

module irq_event_chk #(
  parameter int NSRC   = 10,
  parameter int ADDR_W = 9,
  parameter int DW     = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DW-1:0]     wdata,
  input logic [NSRC-1:0]   evt_in,
  input logic [NSRC-1:0]   pend,
  input logic [NSRC-1:0]   mask,
  input logic [DW-1:0]     ustat,
  input logic              irq
);
  wire [NSRC-1:0] wb = wdata[NSRC-1:0];

  p_w1c_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 9'h000) |=> ((pend & $past(wb & ~evt_in)) == '0));

  p_mask_direct_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (addr == 9'h008 || addr == 9'h00C)) |=> $stable(mask));

  p_unmask_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 9'h008) |=> ((mask & $past(wb)) == '0));

  p_mask_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 9'h00C) |=> ((mask & $past(wb)) == $past(wb)));

  p_force_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 9'h010) |=> ((pend & $past(wb)) == $past(wb)));

  p_irq_quiet_when_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '1) |-> !irq);

  p_scan_bits_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ustat[13]) && $past(ustat[3])) |-> (ustat[13] && ustat[3]));

  p_complete_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ustat[2]);

  p_event_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_in != '0) |=> ((pend & $past(evt_in)) == $past(evt_in)));
endmodule

bind irq_event_ctrl irq_event_chk #(.NSRC(NSRC), .ADDR_W(ADDR_W), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .evt_in(evt_in), .pend(pend), .mask(mask), .ustat(ustat), .irq(irq)
);

// File: tb/sim_irq_event_ctrl.sv
module sim_irq_event_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [8:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [9:0]  evt_in = '0;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [9:0] m_pend, m_mask;

  always #10 clk = ~clk;

  irq_event_ctrl u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .evt_in(evt_in), .irq(irq));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [8:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(logic [8:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic check_model(string req);
    logic [31:0] d;
    rd(9'h000, d); chk({req, " pend"}, d, {22'd0, m_pend});
    rd(9'h004, d); chk({req, " mask"}, d, {22'd0, m_mask});
    chk({req, " irq"}, {31'd0, irq}, {31'd0, |(m_pend & ~m_mask)});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_pend = '0; m_mask = 10'h3FF;

    // reset state: R2 R8
    rd(9'h004, d); chk("R2 mask reset", d, 32'h3FF);
    rd(9'h100, d); chk("R8 ustat reset", d, 32'h4);
    rd(9'h000, d); chk("R1 pend reset", d, 32'h0);
    chk("R6 irq reset", {31'd0, irq}, 32'd0);

    // R2: direct mask write ignored
    wr(9'h004, 32'h0); rd(9'h004, d); chk("R2 direct write ignored", d, 32'h3FF);

    // per-source sweep R3 R4 R5 R6 R1
    for (int k = 0; k < 10; k++) begin
      wr(9'h010, 32'h1 << k); m_pend = 10'h1 << k;
      check_model("R5 force single");
      wr(9'h008, 32'h1 << k); m_mask &= ~(10'h1 << k);
      check_model("R3 unmask single");
      chk("R6 irq raised", {31'd0, irq}, 32'd1);
      wr(9'h00C, 32'h1 << k); m_mask |= 10'h1 << k;
      check_model("R4 mask single");
      wr(9'h008, 32'h1 << k); m_mask &= ~(10'h1 << k);
      wr(9'h000, 32'h1 << k); m_pend = '0;
      check_model("R1 w1c single");
      wr(9'h00C, 32'h3FF); m_mask = 10'h3FF;
    end

    // R1 reserved bits
    wr(9'h010, 32'hFFFF_FFFF); m_pend = 10'h3FF;
    rd(9'h000, d); chk("R1 reserved bits zero", d, 32'h3FF);
    wr(9'h000, 32'h0000_0155); m_pend = 10'h2AA;
    check_model("R1 partial w1c");

    // R9 strobe reads
    rd(9'h008, d); chk("R9 unmask read", d, 0);
    rd(9'h00C, d); chk("R9 mask strobe read", d, 0);
    rd(9'h010, d); chk("R9 force read", d, 0);
    rd(9'h014, d); chk("R9 unmapped read", d, 0);

    // R10 event pulse and same-edge conflict
    wr(9'h000, 32'h3FF); m_pend = '0;
    @(negedge clk); evt_in = 10'h020;
    @(negedge clk); evt_in = '0; m_pend = 10'h020;
    check_model("R10 event sets");
    wr(9'h010, 32'h008); m_pend |= 10'h008;
    @(negedge clk); wr_en = 1'b1; addr = 9'h000; wdata = 32'h028; evt_in = 10'h008;
    @(negedge clk); wr_en = 1'b0; wdata = '0; evt_in = '0; m_pend = 10'h008;
    check_model("R10 event beats clear");

    // R7 R8 control and unit status
    wr(9'h018, 32'h0000_1000);
    rd(9'h018, d); chk("R7 gctl readback", d, 32'h1000);
    rd(9'h100, d); chk("R7 no scan without bit13", d, 32'h4);
    wr(9'h018, 32'hFFFF_FFFF);
    rd(9'h018, d); chk("R7 gctl width", d, 32'h7FFF);
    rd(9'h100, d); chk("R7 scan bits set", d, 32'h200C);
    wr(9'h018, 32'h0);
    rd(9'h100, d); chk("R7 scan bits sticky", d, 32'h200C);
    wr(9'h100, 32'h0);
    rd(9'h100, d); chk("R8 ustat write ignored", d, 32'h200C);

    // mixed sweep against arithmetic model: R1 R3 R4 R5 R6
    for (int i = 0; i < 200; i++) begin
      logic [31:0] v;
      v = (i * 32'd613 + 32'd97) ^ (i << 5);
      case (i % 5)
        0: begin wr(9'h010, v); m_pend |= v[9:0]; end
        1: begin wr(9'h008, v); m_mask &= ~v[9:0]; end
        2: begin wr(9'h000, v); m_pend &= ~v[9:0]; end
        3: begin wr(9'h00C, v); m_mask |= v[9:0]; end
        default: begin wr(9'h004, v); end
      endcase
      check_model("R6 mixed sweep");
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule